// File: doc/BRIEF.md
# Transmit Watermark FIFO

This block is the transmit-side queue of a serial port. A processor or DMA writer pushes data words into a 16-entry FIFO, and a serial shifter pops them, oldest first, from a show-ahead read port. A 16-bit control word holds a 3-bit watermark code. The code picks how many free entries the FIFO must have before the block raises its transfer request to the writer. The same control word also reports the current free space as a read-only 0-to-16 count.

Illegal watermark codes never reach the request logic. The block keeps the last legal code and records the attempt in a sticky flag. Pushes into a full FIFO and pops from an empty one are discarded, and each kind of misuse has its own sticky flag. All three flags are cleared only by reset.

Top module: `tx_fifo_wm`

## Requirements
- R1: After a synchronous active-low reset, `reg_rdata` reads 16'h1000, `tx_req` is 1, `fifo_empty` is 1 and all three error flags are 0. In that value the watermark code 000 sits in bits 15:13, a free count of 16 sits in bits 12:8, and the low byte is 0.
- R2: The FIFO holds 16 words and returns them in the order they were pushed. `rd_data` always shows the oldest stored word, and `fifo_empty` is 1 exactly when no word is stored.
- R3: Bits 12:8 of `reg_rdata` give the free space, which is 16 minus the number of stored words. This field reads 0 when the FIFO is full.
- R4: Each watermark code (bits 15:13) sets a threshold, and the request condition is true when the free count is at least that threshold. The code-to-threshold mapping is 000→16, 100→12, 101→8, 110→4 and 111→1.
- R5: `tx_req` is a register. After each clock edge it holds the R4 condition evaluated on the free count and code from before that edge. It therefore falls one cycle after the free count drops below the threshold.
- R6: A register write carrying code 001, 010 or 011 leaves the stored code unchanged and sets the sticky flag `err_cfg`.
- R7: Bits 7:0 of `reg_rdata` always read 0. Register writes affect only bits 15:13; the data written to bits 12:0 is ignored.
- R8: A push into a full FIFO with no pop in the same cycle is discarded. The stored data and the free count stay unchanged, and the sticky flag `err_ovf` is set.
- R9: A pop from an empty FIFO is discarded and sets the sticky flag `err_udf`. A push in the same cycle is still accepted.
- R10: A push and a pop in the same cycle on a non-empty FIFO, including a full one, leave the free count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Push request from the writer |
| wr_data | input | 16 | Word to push |
| rd_en | input | 1 | Pop request from the shifter |
| rd_data | output | 16 | Oldest stored word (show-ahead) |
| fifo_empty | output | 1 | No word stored |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word: code, free count, zero low byte |
| tx_req | output | 1 | Registered transfer request |
| err_cfg | output | 1 | Sticky: prohibited watermark code written |
| err_ovf | output | 1 | Sticky: push into a full FIFO |
| err_udf | output | 1 | Sticky: pop from an empty FIFO |

## Verification
A wrong occupancy count appears at once in the free-count field of `reg_rdata` and in `fifo_empty`. One cycle later it reaches `tx_req`, so every fill level around each threshold is checked both in the cycle the count settles and in the cycle after. A corrupted read or write pointer shows up as a wrong word on `rd_data` during the drain that follows each fill. A bad code being accepted shows up in bits 15:13 on the cycle after the write.

// File: rtl/txfifo_pkg.sv
// Package: shared constants and helpers for the transmit watermark FIFO.
// Assumes the control word is 16 bits, laid out as code | free count | zero byte.
package txfifo_pkg;

    localparam int CTRL_W   = 16;
    localparam int WM_W     = 3;
    localparam int FREE_W   = 5;
    localparam int PAD_W    = CTRL_W - WM_W - FREE_W;
    localparam int WM_LSB   = CTRL_W - WM_W;
    localparam int FREE_LSB = PAD_W;

    typedef logic [WM_W-1:0] wm_code_t;

    localparam wm_code_t WM_ALL     = 3'b000;
    localparam wm_code_t WM_QUARTER = 3'b100;
    localparam wm_code_t WM_HALF    = 3'b101;
    localparam wm_code_t WM_3QUART  = 3'b110;
    localparam wm_code_t WM_ANY     = 3'b111;

    // Legal codes are the ones with a defined threshold.
    function automatic logic wm_legal(wm_code_t code);
        return (code == WM_ALL) || code[2];
    endfunction

    // Free entries needed before a request is raised.
    function automatic int unsigned wm_threshold(wm_code_t code, int unsigned depth);
        case (code)
            WM_QUARTER: return (depth * 3) / 4;
            WM_HALF:    return depth / 2;
            WM_3QUART:  return depth / 4;
            WM_ANY:     return 1;
            default:    return depth;
        endcase
    endfunction

endpackage

// File: rtl/txfifo_store.sv
// Module: circular data store with wrap-around read and write pointers.
// Assumes the caller only asserts push_ok/pop_ok when the operation is legal.
module txfifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_ok,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_ok,
    output logic [DATA_W-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    // Advance a pointer by one entry, wrapping after the last one.
    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Pointer update on accepted push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
        end
    end

    // Data write into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign head_data = mem[rd_ptr];

endmodule

// File: rtl/txfifo_occ.sv
// Module: occupancy tracking, accept decisions and sticky misuse flags.
// Assumes push and pop are single-cycle strobes; flags clear only on reset.
module txfifo_occ #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] free_cnt,
    output logic             empty,
    output logic             ovf_flag,
    output logic             udf_flag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] used_cnt;
    logic             full;

    assign full    = (used_cnt == FULL_CNT);
    assign empty   = (used_cnt == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign free_cnt = FULL_CNT - used_cnt;

    // Stored-word count follows accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_cnt <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   used_cnt <= used_cnt + 1'b1;
                2'b01:   used_cnt <= used_cnt - 1'b1;
                default: used_cnt <= used_cnt;
            endcase
        end
    end

    // Sticky records of rejected pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (push && !push_ok) ovf_flag <= 1'b1;
            if (pop && empty)     udf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/txfifo_cfg.sv
// Module: watermark code register with rejection of prohibited codes.
// Assumes only the code bits of the written word matter.
module txfifo_cfg
    import txfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output wm_code_t          code,
    output logic              cfg_err
);
    wm_code_t new_code;
    logic     unused_low;

    assign new_code   = wdata[WM_LSB +: WM_W];
    assign unused_low = ^wdata[WM_LSB-1:0];

    // Keep the last legal code; flag prohibited ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code    <= WM_ALL;
            cfg_err <= 1'b0;
        end else if (wr_en) begin
            if (wm_legal(new_code)) code    <= new_code;
            else                    cfg_err <= 1'b1;
        end
    end

endmodule

// File: rtl/txfifo_req.sv
// Module: registered transfer request from free count and watermark code.
// Assumes the code is always legal (guaranteed by the code register).
module txfifo_req
    import txfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wm_code_t         code,
    input  logic [CNT_W-1:0] free_cnt,
    output logic             req
);
    logic [CNT_W-1:0] thresh;

    assign thresh = CNT_W'(wm_threshold(code, DEPTH));

    // Re-evaluate the request every cycle; reset matches the empty FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b1;
        else        req <= (free_cnt >= thresh);
    end

endmodule

// File: rtl/tx_fifo_wm.sv
// Module: transmit FIFO with watermark-driven transfer request (top).
// Assumes DEPTH fits the 5-bit free field of the control word.
module tx_fifo_wm
    import txfifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              fifo_empty,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              tx_req,
    output logic              err_cfg,
    output logic              err_ovf,
    output logic              err_udf
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_ok;
    logic             pop_ok;
    logic [CNT_W-1:0] free_cnt;
    wm_code_t         wm_code;

    txfifo_occ #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .pop(rd_en),
        .push_ok(push_ok), .pop_ok(pop_ok), .free_cnt(free_cnt),
        .empty(fifo_empty), .ovf_flag(err_ovf), .udf_flag(err_udf)
    );

    txfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .push_data(wr_data),
        .pop_ok(pop_ok), .head_data(rd_data)
    );

    txfifo_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
        .code(wm_code), .cfg_err(err_cfg)
    );

    txfifo_req #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_req (
        .clk(clk), .rst_n(rst_n), .code(wm_code), .free_cnt(free_cnt),
        .req(tx_req)
    );

    assign reg_rdata = {wm_code, FREE_W'(free_cnt), {PAD_W{1'b0}}};

endmodule

// File: rtl/tx_fifo_wm_chk.sv
// Module: port-level property checker for tx_fifo_wm, attached by bind.
// Assumes the control word layout of txfifo_pkg.
module tx_fifo_wm_chk
    import txfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              rd_en,
    input logic              fifo_empty,
    input logic              reg_wr,
    input logic [CTRL_W-1:0] reg_wdata,
    input logic [CTRL_W-1:0] reg_rdata,
    input logic              tx_req,
    input logic              err_cfg,
    input logic              err_ovf,
    input logic              err_udf
);
    logic [FREE_W-1:0] free_f;
    wm_code_t          code_f;
    logic [FREE_W-1:0] thr_f;

    assign free_f = reg_rdata[FREE_LSB +: FREE_W];
    assign code_f = reg_rdata[WM_LSB +: WM_W];
    assign thr_f  = FREE_W'(wm_threshold(code_f, DEPTH));

    assert_free_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        free_f <= FREE_W'(DEPTH));

    assert_empty_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty == (free_f == FREE_W'(DEPTH)));

    assert_req_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tx_req == ($past(free_f) >= $past(thr_f)));

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !wm_legal(reg_wdata[WM_LSB +: WM_W]) |=> $stable(code_f) && err_cfg);

    assert_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[PAD_W-1:0] == '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_f == '0) && wr_valid && !rd_en |=> (free_f == '0) && err_ovf);

    assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_udf |=> err_udf);

    assert_hold_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && rd_en && !fifo_empty |=> $stable(free_f));

endmodule

bind tx_fifo_wm tx_fifo_wm_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_en(rd_en),
    .fifo_empty(fifo_empty), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_req(tx_req), .err_cfg(err_cfg),
    .err_ovf(err_ovf), .err_udf(err_udf)
);

// File: tb/sim_tx_fifo_wm.sv
// Bench: vector table over watermark codes and fill levels, then directed tests.
module sim_tx_fifo_wm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        fifo_empty;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_req;
    logic        err_cfg, err_ovf, err_udf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tx_fifo_wm u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_req(tx_req), .err_cfg(err_cfg), .err_ovf(err_ovf), .err_udf(err_udf)
    );

    // {code[2:0], fill[4:0], expected request}
    localparam int NV = 11;
    localparam logic [8:0] VECS [NV] = '{
        {3'b000, 5'd0,  1'b1}, {3'b000, 5'd1,  1'b0},
        {3'b100, 5'd4,  1'b1}, {3'b100, 5'd5,  1'b0},
        {3'b101, 5'd8,  1'b1}, {3'b101, 5'd9,  1'b0},
        {3'b110, 5'd12, 1'b1}, {3'b110, 5'd13, 1'b0},
        {3'b111, 5'd15, 1'b1}, {3'b111, 5'd16, 1'b0},
        {3'b000, 5'd16, 1'b0}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] d);
        wr_valid = 1'b1; wr_data = d; step(); wr_valid = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1; step(); rd_en = 1'b0;
    endtask

    task automatic set_code(input logic [2:0] c, input logic [12:0] low);
        reg_wr = 1'b1; reg_wdata = {c, low}; step(); reg_wr = 1'b0;
    endtask

    task automatic drain();
        while (!fifo_empty) pop();
    endtask

    task automatic fill_n(input int n, input logic [7:0] tag);
        for (int j = 0; j < n; j++) push({tag, 8'(j)});
    endtask

    task automatic check_reset(input string tag);
        check(reg_rdata == 16'h1000, tag, reg_rdata, 16'h1000);
        check(tx_req && fifo_empty && !err_cfg && !err_ovf && !err_udf, tag,
              {tx_req, fifo_empty, err_cfg, err_ovf, err_udf}, 5'b11000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        check_reset("R1 reset state");

        // Vector table: code vs fill level (R3, R4, R5), data order (R2).
        for (int i = 0; i < NV; i++) begin
            logic [2:0] c   = VECS[i][8:6];
            int         n   = int'(VECS[i][5:1]);
            logic       exq = VECS[i][0];
            bit         order_ok = 1'b1;
            set_code(c, 13'h0);
            fill_n(n, 8'(i));
            step();
            check(reg_rdata[12:8] == 5'(16 - n), $sformatf("R3 free vec%0d", i),
                  reg_rdata[12:8], 16 - n);
            check(tx_req == exq, $sformatf("R4 request vec%0d", i), tx_req, exq);
            for (int j = 0; j < n; j++) begin
                if (rd_data != {8'(i), 8'(j)}) order_ok = 1'b0;
                pop();
            end
            check(order_ok && fifo_empty, $sformatf("R2 order vec%0d", i),
                  {order_ok, fifo_empty}, 2'b11);
            step();
        end

        // R5: request falls one cycle after free count drops below threshold.
        set_code(3'b111, 13'h0);
        fill_n(15, 8'hA0);
        step();
        check(tx_req == 1'b1, "R5 req before fill", tx_req, 1);
        push(16'hA00F);
        check(tx_req == 1'b1, "R5 req same cycle as full", tx_req, 1);
        step();
        check(tx_req == 1'b0, "R5 req one cycle later", tx_req, 0);

        // R8: push into full FIFO is discarded.
        check(err_ovf == 1'b0, "R8 flag clear before", err_ovf, 0);
        push(16'hDEAD);
        check(reg_rdata[12:8] == 5'd0 && err_ovf, "R8 overflow",
              {reg_rdata[12:8], err_ovf}, {5'd0, 1'b1});
        begin
            logic [15:0] last = '0;
            while (!fifo_empty) begin last = rd_data; pop(); end
            check(last == 16'hA00F, "R8 stored data intact", last, 16'hA00F);
        end

        // R9: pop from empty is discarded; push in same cycle accepted.
        check(err_udf == 1'b0, "R9 flag clear before", err_udf, 0);
        pop();
        check(reg_rdata[12:8] == 5'd16 && err_udf, "R9 underflow",
              {reg_rdata[12:8], err_udf}, {5'd16, 1'b1});
        wr_valid = 1'b1; rd_en = 1'b1; wr_data = 16'h5A5A; step();
        wr_valid = 1'b0; rd_en = 1'b0;
        check(reg_rdata[12:8] == 5'd15 && rd_data == 16'h5A5A, "R9 push kept on empty pop",
              {reg_rdata[12:8], rd_data}, {5'd15, 16'h5A5A});
        drain();

        // R10: simultaneous push and pop keeps count (partial and full).
        fill_n(5, 8'hB0);
        wr_valid = 1'b1; rd_en = 1'b1; wr_data = 16'hB0FF; step();
        wr_valid = 1'b0; rd_en = 1'b0;
        check(reg_rdata[12:8] == 5'd11 && rd_data == 16'hB001, "R10 partial",
              {reg_rdata[12:8], rd_data}, {5'd11, 16'hB001});
        fill_n(11, 8'hB1);
        wr_valid = 1'b1; rd_en = 1'b1; wr_data = 16'hBEEF; step();
        wr_valid = 1'b0; rd_en = 1'b0;
        check(reg_rdata[12:8] == 5'd0, "R10 full", reg_rdata[12:8], 0);
        begin
            logic [15:0] last = '0;
            while (!fifo_empty) begin last = rd_data; pop(); end
            check(last == 16'hBEEF, "R10 full push kept", last, 16'hBEEF);
        end

        // R6: prohibited codes keep the previous legal code.
        set_code(3'b101, 13'h0);
        check(err_cfg == 1'b0, "R6 flag clear before", err_cfg, 0);
        set_code(3'b011, 13'h0);
        check(reg_rdata[15:13] == 3'b101 && err_cfg, "R6 code 011 rejected",
              {reg_rdata[15:13], err_cfg}, {3'b101, 1'b1});
        set_code(3'b001, 13'h0);
        check(reg_rdata[15:13] == 3'b101, "R6 code 001 rejected", reg_rdata[15:13], 3'b101);

        // R7: low bits of writes ignored, low byte reads zero.
        set_code(3'b110, 13'h03FF);
        check(reg_rdata == 16'hD000, "R7 low bits ignored", reg_rdata, 16'hD000);

        // R1: reset mid-operation restores the reset state.
        fill_n(3, 8'hC0);
        rst_n = 1'b0; step();
        rst_n = 1'b1;
        check_reset("R1 reset after traffic");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule